// File: doc/BRIEF.md
# DCT Transpose Buffer Controller

This block sits between the row pass and the column pass of a separable 8x8 two-dimensional DCT. The row pass writes its 16-bit results into a single 64-entry store. The column pass reads the previous block back transposed. Both passes run at the same time, so the transform stays pipelined. One store is enough because the order in which addresses are walked flips on every block.

The scan counter for each block produces addresses in one of two ways: `{row, col}` (row scan) or `{col, row}` (column scan). The store reads and writes in the same clock cycle, and a read returns the location's old contents. The writer can therefore refill a location in the cycle it is drained. Reading of a block starts only after all 64 of its samples have been written. From then on, the writer is held back so that it never overtakes the reader. The reader is idle until a complete block exists.

Top module: `dct_tpose_buf`

## Requirements
- R1: After reset `rd_valid_o`, `rd_first_o` and `rd_last_o` are 0, and `wr_ready_o` is 1 while no complete block is held. The first block after reset is written in row scan.
- R2: No read is granted for a block until all 64 of its samples have been accepted. `rd_valid_o` stays 0 while `rd_req_i` is held high during the first 64 writes.
- R3: Samples of a block are accepted in row-major order, so input index k = 8*row + col. Output sample j of the same block is input sample (j mod 8)*8 + (j div 8), which is the transpose.
- R4: R3 holds for every block of an unbroken sequence, including blocks whose writes overlap the reads of the block before them. This depends on the scan mode alternating at each block boundary and on each read returning the data held before a write in the same cycle.
- R5: While a complete block is pending, `wr_ready_o` is 1 only if the write position within the block is behind the read position, or equal to it with a read granted in the same cycle. A `wr_data_i` value offered while `wr_ready_o` is 0 is not stored.
- R6: With `rd_req_i` and `wr_valid_i` held high, once the first block is full one sample is written and one is read in every cycle, and `wr_ready_o` never drops.
- R7: A read is granted when `rd_req_i` is 1 and a complete block is pending. `rd_valid_o` is 1 in exactly the cycle after a grant, with the sample on `rd_data_o`.
- R8: `rd_first_o` marks output sample 0 and `rd_last_o` marks output sample 63 of each block. Both are 1 only together with `rd_valid_o`.
- R9: Dropping `rd_req_i` pauses output. No sample is lost or repeated, and the writer stalls only as R5 demands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Row pass offers a sample |
| wr_data_i | input | 16 | Sample from the row pass |
| wr_ready_o | output | 1 | Sample is accepted this cycle when `wr_valid_i` is also 1 |
| rd_req_i | input | 1 | Column pass asks for the next sample |
| rd_valid_o | output | 1 | `rd_data_o` holds a granted sample |
| rd_data_o | output | 16 | Transposed sample to the column pass |
| rd_first_o | output | 1 | Output sample is the first of its block |
| rd_last_o | output | 1 | Output sample is the last of its block |

## Verification
Suppose a scan counter or a mode bit is wrong. The next block then leaves in the wrong order, or with the previous block's samples mixed in, and the first bad word shows on `rd_data_o` one cycle after its grant. A wrong pending-block flag shows earlier. It either grants reads before a block is full, so `rd_valid_o` rises during the first 64 writes, or it drops `wr_ready_o` in the same cycle the reader falls behind. The bench sweeps several regular valid and request patterns over many blocks and predicts every ready, valid, flag and data value from the sample counts alone.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

  typedef enum logic {
    MODE_ROW = 1'b0,
    MODE_COL = 1'b1
  } scan_mode_e;

  function automatic scan_mode_e flip_mode(scan_mode_e m);
    return (m == MODE_ROW) ? MODE_COL : MODE_ROW;
  endfunction

endpackage

// File: rtl/tbuf_scan.sv
module tbuf_scan
  import tbuf_pkg::*;
#(
  parameter int         SIDE_LOG2 = 3,
  parameter scan_mode_e RST_MODE  = MODE_ROW,
  parameter int         POS_W     = 2 * SIDE_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] addr_o,
  output logic             last_o,
  output scan_mode_e       mode_o
);

  logic [POS_W-1:0]     pos_q;
  scan_mode_e           mode_q;
  logic [SIDE_LOG2-1:0] major, minor;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mode_q <= RST_MODE;
    end else if (step_i) begin
      pos_q <= pos_q + 1'b1;
      if (last_o) mode_q <= flip_mode(mode_q);
    end
  end

  assign major  = pos_q[POS_W-1:SIDE_LOG2];
  assign minor  = pos_q[SIDE_LOG2-1:0];
  assign last_o = &pos_q;
  assign pos_o  = pos_q;
  assign mode_o = mode_q;

  // row scan walks {row,col}; column scan swaps the halves
  always_comb begin
    if (mode_q == MODE_ROW) addr_o = pos_q;
    else                    addr_o = {minor, major};
  end

  // R3
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pos_q == POS_W'($past(pos_q) + 1'b1));

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && last_o) |=> mode_q == $past(mode_q));

endmodule

// File: rtl/tbuf_ram.sv
module tbuf_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // nonblocking read sees the old word when waddr == raddr
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_q <= mem[raddr_i];
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/tbuf_flow.sv
module tbuf_flow #(
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             rd_req_i,
  input  logic [POS_W-1:0] wr_pos_i,
  input  logic [POS_W-1:0] rd_pos_i,
  input  logic             wr_last_i,
  input  logic             rd_last_i,
  output logic             wr_ready_o,
  output logic             wr_fire_o,
  output logic             rd_fire_o,
  output logic             avail_o
);

  logic avail_q;
  logic wr_done, rd_done;

  assign rd_fire_o  = rd_req_i && avail_q;
  // pending block: writer may fill only slots already drained (or draining now)
  assign wr_ready_o = !avail_q
                   || (wr_pos_i < rd_pos_i)
                   || ((wr_pos_i == rd_pos_i) && rd_fire_o);
  assign wr_fire_o  = wr_valid_i && wr_ready_o;

  assign wr_done = wr_fire_o && wr_last_i;
  assign rd_done = rd_fire_o && rd_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      avail_q <= 1'b0;
    else if (wr_done) avail_q <= 1'b1;
    else if (rd_done) avail_q <= 1'b0;
  end

  assign avail_o = avail_q;

  // R2
  avail_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> avail_q);

  // R9
  avail_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && !wr_done) |=> !avail_q);

endmodule

// File: rtl/dct_tpose_buf.sv
module dct_tpose_buf
  import tbuf_pkg::*;
#(
  parameter int DIM_LOG2 = 3,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_first_o,
  output logic              rd_last_o
);

  localparam int POS_W = 2 * DIM_LOG2;

  logic             wr_fire, rd_fire, avail;
  logic [POS_W-1:0] wr_pos, rd_pos, wr_addr, rd_addr;
  logic             wr_last, rd_last;
  scan_mode_e       wr_mode, rd_mode;
  logic             rd_valid_q, rd_first_q, rd_last_q;

  // writer starts in row scan; reader runs one mode behind
  tbuf_scan #(.SIDE_LOG2(DIM_LOG2), .RST_MODE(MODE_ROW)) u_wr_scan (
    .clk_i (clk_i), .rst_ni (rst_ni), .step_i (wr_fire),
    .pos_o (wr_pos), .addr_o (wr_addr), .last_o (wr_last), .mode_o (wr_mode)
  );

  tbuf_scan #(.SIDE_LOG2(DIM_LOG2), .RST_MODE(MODE_COL)) u_rd_scan (
    .clk_i (clk_i), .rst_ni (rst_ni), .step_i (rd_fire),
    .pos_o (rd_pos), .addr_o (rd_addr), .last_o (rd_last), .mode_o (rd_mode)
  );

  tbuf_flow #(.POS_W(POS_W)) u_flow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .rd_req_i   (rd_req_i),
    .wr_pos_i   (wr_pos),
    .rd_pos_i   (rd_pos),
    .wr_last_i  (wr_last),
    .rd_last_i  (rd_last),
    .wr_ready_o (wr_ready_o),
    .wr_fire_o  (wr_fire),
    .rd_fire_o  (rd_fire),
    .avail_o    (avail)
  );

  tbuf_ram #(.ADDR_W(POS_W), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .re_i    (rd_fire),
    .raddr_i (rd_addr),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_first_q <= 1'b0;
      rd_last_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_fire;
      rd_first_q <= rd_fire && (rd_pos == '0);
      rd_last_q  <= rd_fire && rd_last;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_first_o = rd_first_q;
  assign rd_last_o  = rd_last_q;

  // R7
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));

  // R8
  flag_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_first_o || rd_last_o) |-> rd_valid_o);

  // R4
  mode_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail == (wr_mode == rd_mode));

endmodule

// File: tb/dct_tpose_buf_bench.sv
module dct_tpose_buf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 64;
  localparam int SIDE       = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        wr_ready_o;
  logic        rd_req_i = 1'b0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        rd_first_o, rd_last_o;

  int n_run = 0, n_fail = 0;
  int wr_tot = 0, rd_tot = 0, out_tot = 0, limit = 0;
  int stall_cnt = 0, cyc = 0;
  bit pend_fire = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dct_tpose_buf u_dct_tpose_buf (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_valid_i (wr_valid_i), .wr_data_i (wr_data_i), .wr_ready_o (wr_ready_o),
    .rd_req_i (rd_req_i), .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o),
    .rd_first_o (rd_first_o), .rd_last_o (rd_last_o)
  );

  function automatic logic [15:0] data_of(int idx);
    return 16'((idx / BLK) * 256 + (idx % BLK)) ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: observe registered outputs, drive inputs, predict ready
  task automatic step(bit wv, bit rr);
    bit avail, fire, exp_rdy, do_w;
    int wpos, rpos;
    @(negedge clk_i);
    chk(rd_valid_o == pend_fire, "R7", "rd_valid_o", rd_valid_o, pend_fire);
    if (rd_valid_o && pend_fire) begin
      int j = out_tot % BLK;
      int b = out_tot / BLK;
      int src = b * BLK + (j % SIDE) * SIDE + j / SIDE;
      chk(rd_data_o == data_of(src), (b > 0) ? "R4" : "R3", "rd_data_o",
          rd_data_o, data_of(src));
      chk(rd_first_o == (j == 0), "R8", "rd_first_o", rd_first_o, j == 0);
      chk(rd_last_o == (j == BLK - 1), "R8", "rd_last_o", rd_last_o, j == BLK - 1);
      out_tot++;
    end else begin
      chk(!rd_first_o && !rd_last_o, "R8", "flags idle", {rd_first_o, rd_last_o}, 0);
    end
    avail   = wr_tot >= (rd_tot / BLK + 1) * BLK;
    fire    = rr && avail;
    wpos    = wr_tot % BLK;
    rpos    = rd_tot % BLK;
    exp_rdy = !avail || (wpos < rpos) || ((wpos == rpos) && fire);
    do_w    = wv && (wr_tot < limit);
    wr_valid_i = do_w;
    // R5: junk offered while stalled must not land in the store
    wr_data_i  = exp_rdy ? data_of(wr_tot) : 16'hDEAD;
    rd_req_i   = rr;
    #1;
    chk(wr_ready_o == exp_rdy, "R5", "wr_ready_o", wr_ready_o, exp_rdy);
    if (do_w && !wr_ready_o) stall_cnt++;
    if (do_w && exp_rdy) wr_tot++;
    if (fire) rd_tot++;
    pend_fire = fire;
    cyc++;
  endtask

  task automatic drain();
    while (out_tot < limit) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", out_tot, limit);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state
    chk(rd_valid_o == 1'b0, "R1", "rd_valid_o", rd_valid_o, 0);
    chk(rd_first_o == 1'b0 && rd_last_o == 1'b0, "R1", "flags", {rd_first_o, rd_last_o}, 0);
    chk(wr_ready_o == 1'b1, "R1", "wr_ready_o", wr_ready_o, 1);
    rst_ni = 1'b1;

    // R2/R6: continuous stream, first block row scan (R1)
    limit = 5 * BLK;
    for (int i = 0; i < BLK; i++) step(1'b1, 1'b1);
    chk(out_tot == 0 && wr_tot == BLK, "R2", "outputs before block full", out_tot, 0);
    stall_cnt = 0;
    while (wr_tot < limit) step(1'b1, 1'b1);
    // R6: no stall once streaming
    chk(stall_cnt == 0, "R6", "stall cycles", stall_cnt, 0);
    chk(out_tot == limit - BLK - 1, "R6", "outputs while streaming", out_tot, limit - BLK - 1);
    drain();

    // sparse producer
    limit += 3 * BLK; cyc = 0;
    while (wr_tot < limit) step(cyc % 3 != 0, 1'b1);
    drain();

    // R5/R9: slow consumer forces producer stalls
    limit += 3 * BLK; cyc = 0; stall_cnt = 0;
    while (wr_tot < limit) step(1'b1, (cyc % 7) < 3);
    chk(stall_cnt > 0, "R5", "producer stalled", stall_cnt, 1);
    drain();

    // R9: long consumer pause, bursty producer
    limit += 3 * BLK; cyc = 0;
    while (wr_tot < limit) step((cyc % 16) < 12, (cyc < 100) ? 1'b0 : ((cyc % 9) != 4));
    drain();

    // mixed irregular pattern
    limit += 3 * BLK; cyc = 0;
    while (wr_tot < limit) step(((cyc * 5) % 11) > 3, ((cyc * 3) % 13) > 4);
    drain();

    chk(out_tot == limit, "R9", "total outputs", out_tot, limit);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule